// File: doc/BRIEF.md
# Manual SDRAM Command Front End

This block lets a host processor push one manual command at a time to an external SDRAM sequencer. The host talks to it over a small word-addressed register bus. It loads a target address and, when the command needs one, a data word. It then writes the command register. That write must carry an unlock key in its upper half and a 4-bit opcode in its low bits.

When the key and the opcode are both acceptable, the block latches the opcode, address and data into a request. It presents that request to the sequencer under a valid/acknowledge handshake. The sequencer's answer sets a sticky done or error bit, and a successful read deposits the returned word in a receive register. A command that fails the key or opcode check never reaches the sequencer; it only raises the error bit. An enable mask selects which status bits drive one level-sensitive interrupt line.

Register offsets, in 32-bit words on `busAddr`:

| Offset | Register | Access |
|---|---|---|
| 0 | target address | read/write |
| 1 | transmit data | read/write |
| 2 | receive data | read only |
| 3 | command | write, reads back the last opcode |
| 4 | status | write-one-to-clear |
| 5 | interrupt enable | read/write |

Any other offset reads as zero.

Top module: `memcmd_front`

## Requirements
- R1: After reset, status reads 0, the interrupt output is 0, `reqValid` is 0, and receive data reads 0.
- R2: Target address (offset 0) and transmit data (offset 1) read back what was last written. A bus write to receive data (offset 2) leaves its value unchanged.
- R3: The host writes offset 3 while no command is in flight, with bits 31:16 equal to 0xA55A and bits 3:0 an opcode from 0x8 to 0xF. One clock later `reqValid` is 1. At that point `reqOp` carries the opcode, `reqAddr` the target address register and `reqData` the transmit data register.
- R4: While `reqValid` is 1 and `reqAck` is 0, the request and its payload stay unchanged. In the cycle after `reqAck` is sampled at 1, `reqValid` is 0.
- R5: An acknowledge with `ackErr` at 0 sets status bit 0 (done). An acknowledge with `ackErr` at 1 sets status bit 1 (error).
- R6: An acknowledged opcode 0x8 (read) with `ackErr` at 0 loads `ackData` into receive data. No other acknowledge changes receive data.
- R7: A command write whose bits 31:16 differ from 0xA55A sets status bit 1 one clock later and raises no request.
- R8: A command write with opcode 0x0 to 0x7 sets status bit 1 and raises no request. This includes 0x0 and 0x1, the host-bus read and write codes.
- R9: A command write while a request is in flight sets status bit 1. It leaves the pending request and its payload untouched.
- R10: Writing status clears each bit written as 1 and keeps each bit written as 0. When a set and a clear of the same bit fall in one cycle, the set wins.
- R11: `irq` is 1 exactly when some status bit is 1 and the interrupt enable register (offset 5) has 1 in the same position (bit 0 done, bit 1 error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | REG_AW | Register word offset |
| busWdata | input | DATA_W | Register write data |
| busRdata | output | DATA_W | Register read data (combinational on busAddr) |
| reqValid | output | 1 | Request to the sequencer pending |
| reqOp | output | 4 | Request opcode |
| reqAddr | output | ADDR_W | Request target address |
| reqData | output | DATA_W | Request write / mode data |
| reqAck | input | 1 | Sequencer accepts and completes the request |
| ackErr | input | 1 | Sequencer reports failure with the acknowledge |
| ackData | input | DATA_W | Read data returned with the acknowledge |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle and must be tested together.

The first pair is the sequencer's acknowledge setting the done bit while the host writes a one to the same bit to clear it. The bench raises `reqAck` and a status write with bit 0 set in the same cycle, then reads status. It expects done to be 1, because the set wins.

The second pair is a command write that lands while a request is pending. The bench holds back the acknowledge and issues the write. It then judges the result by three things: the error bit, an unchanged request payload, and the single done bit that follows the one acknowledge.

// File: rtl/memcmd_pkg.sv
package memcmd_pkg;

  typedef struct packed {
    logic launch;
    logic setDone;
    logic setErr;
    logic capRx;
  } ctrlStrobe_t;

  localparam int unsigned OFF_ADDR = 0;
  localparam int unsigned OFF_TXD  = 1;
  localparam int unsigned OFF_RXD  = 2;
  localparam int unsigned OFF_CMD  = 3;
  localparam int unsigned OFF_STAT = 4;
  localparam int unsigned OFF_IEN  = 5;

  localparam int unsigned OP_W    = 4;
  localparam logic [3:0]  OP_READ = 4'h8;
  localparam int unsigned STAT_W  = 2;

endpackage

// File: rtl/memcmd_ctrl.sv
module memcmd_ctrl
  import memcmd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 3,
  parameter int unsigned KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA55A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              reqAck,
  input  logic              ackErr,
  output logic              reqValid,
  output ctrlStrobe_t       strobe
);

  logic busyQ;
  logic pendReadQ;
  logic cmdWr;
  logic keyOk;
  logic opOk;
  logic [OP_W-1:0] opVal;
  logic ackSeen;

  assign cmdWr   = busWr && (busAddr == REG_AW'(OFF_CMD));
  assign keyOk   = (busWdata[DATA_W-1 -: KEY_W] == KEY);
  assign opVal   = busWdata[OP_W-1:0];
  // manual codes occupy the upper half of the opcode space
  assign opOk    = opVal[OP_W-1];
  assign ackSeen = busyQ && reqAck;

  always_comb begin
    strobe.launch  = cmdWr && !busyQ && keyOk && opOk;
    strobe.setErr  = (cmdWr && (busyQ || !keyOk || !opOk)) || (ackSeen && ackErr);
    strobe.setDone = ackSeen && !ackErr;
    strobe.capRx   = ackSeen && !ackErr && pendReadQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      pendReadQ <= 1'b0;
    end else if (strobe.launch) begin
      busyQ     <= 1'b1;
      pendReadQ <= (opVal == OP_READ);
    end else if (ackSeen) begin
      busyQ     <= 1'b0;
      pendReadQ <= 1'b0;
    end
  end

  assign reqValid = busyQ;

endmodule

// File: rtl/memcmd_dpath.sv
module memcmd_dpath
  import memcmd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] ackData,
  output logic [DATA_W-1:0] busRdata,
  output logic [OP_W-1:0]   reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic [STAT_W-1:0] statusQ,
  output logic              irq
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] txQ;
  logic [DATA_W-1:0] rxQ;
  logic [STAT_W-1:0] ienQ;
  logic [OP_W-1:0]   lastOpQ;
  logic [STAT_W-1:0] statSet;
  logic [STAT_W-1:0] statClr;

  function automatic logic selHit(input logic [REG_AW-1:0] a, input int unsigned off);
    return a == REG_AW'(off);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      txQ     <= '0;
      ienQ    <= '0;
      lastOpQ <= '0;
    end else begin
      if (busWr && selHit(busAddr, OFF_ADDR)) addrQ <= busWdata[ADDR_W-1:0];
      if (busWr && selHit(busAddr, OFF_TXD))  txQ   <= busWdata;
      if (busWr && selHit(busAddr, OFF_IEN))  ienQ  <= busWdata[STAT_W-1:0];
      if (strobe.launch)                      lastOpQ <= busWdata[OP_W-1:0];
    end
  end

  // request payload frozen at launch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqOp   <= '0;
      reqAddr <= '0;
      reqData <= '0;
    end else if (strobe.launch) begin
      reqOp   <= busWdata[OP_W-1:0];
      reqAddr <= addrQ;
      reqData <= txQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxQ <= '0;
    else if (strobe.capRx) rxQ <= ackData;
  end

  assign statSet = {strobe.setErr, strobe.setDone};
  assign statClr = (busWr && selHit(busAddr, OFF_STAT)) ? busWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~statClr) | statSet;
  end

  assign irq = |(statusQ & ienQ);

  always_comb begin
    busRdata = '0;
    if (selHit(busAddr, OFF_ADDR))      busRdata = DATA_W'(addrQ);
    else if (selHit(busAddr, OFF_TXD))  busRdata = txQ;
    else if (selHit(busAddr, OFF_RXD))  busRdata = rxQ;
    else if (selHit(busAddr, OFF_CMD))  busRdata = DATA_W'(lastOpQ);
    else if (selHit(busAddr, OFF_STAT)) busRdata = DATA_W'(statusQ);
    else if (selHit(busAddr, OFF_IEN))  busRdata = DATA_W'(ienQ);
  end

endmodule

// File: rtl/memcmd_front.sv
module memcmd_front
  import memcmd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 3,
  parameter int unsigned KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA55A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              reqValid,
  output logic [3:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  input  logic              reqAck,
  input  logic              ackErr,
  input  logic [DATA_W-1:0] ackData,
  output logic              irq
);

  ctrlStrobe_t       strobe;
  logic [STAT_W-1:0] statusQ;

  memcmd_ctrl #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .KEY_W(KEY_W), .KEY(KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .reqAck(reqAck), .ackErr(ackErr),
    .reqValid(reqValid), .strobe(strobe)
  );

  memcmd_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .ackData(ackData),
    .busRdata(busRdata), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .statusQ(statusQ), .irq(irq)
  );

endmodule

// File: rtl/memcmd_front_chk.sv
module memcmd_front_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 3,
  parameter int unsigned KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA55A
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [REG_AW-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              reqValid,
  input logic [3:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqData,
  input logic              reqAck,
  input logic              ackErr,
  input logic [1:0]        statusQ
);

  logic cmdWr;
  logic keyOk;
  assign cmdWr = busWr && (busAddr == REG_AW'(3));
  assign keyOk = (busWdata[DATA_W-1 -: KEY_W] == KEY);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqOp) && $stable(reqAddr) && $stable(reqData)); // R4

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAck |=> !reqValid); // R4

  AST_OP_MANUAL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqOp[3]); // R8

  AST_LAUNCH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(cmdWr && keyOk)); // R3

  AST_BADKEY_ERR: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !keyOk && !reqValid |=> statusQ[1] && !reqValid); // R7

  AST_BUSY_ERR: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && reqValid && !reqAck |=> statusQ[1] && reqValid && $stable(reqAddr)); // R9

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAck && !ackErr |=> statusQ[0]); // R5

endmodule

bind memcmd_front memcmd_front_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW), .KEY_W(KEY_W), .KEY(KEY)
) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
  .reqAck(reqAck), .ackErr(ackErr), .statusQ(statusQ)
);

// File: tb/memcmd_front_tb.sv
module memcmd_front_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY = 16'hA55A;
  localparam logic [2:0] A_ADDR = 3'd0, A_TXD = 3'd1, A_RXD = 3'd2,
                         A_CMD = 3'd3, A_STAT = 3'd4, A_IEN = 3'd5;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] addr;
    logic [31:0] tx;
    logic        aErr;
    logic [31:0] aData;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'h8, 32'h0000_1000, 32'h0000_0000, 1'b0, 32'hDEAD_BEEF},
    '{4'h9, 32'h0000_2000, 32'h1234_5678, 1'b0, 32'hFFFF_FFFF},
    '{4'hA, 32'h0000_0000, 32'h0000_0032, 1'b0, 32'h0000_0001},
    '{4'hF, 32'h8000_0000, 32'h0000_0000, 1'b1, 32'h0000_0002},
    '{4'h8, 32'h0000_0040, 32'h0000_0000, 1'b1, 32'h0000_5555},
    '{4'h8, 32'h0000_0044, 32'hAAAA_0000, 1'b0, 32'h0BAD_F00D},
    '{4'hC, 32'h0000_0100, 32'h0000_0000, 1'b0, 32'h7777_7777}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        reqValid;
  logic [3:0]  reqOp;
  logic [31:0] reqAddr;
  logic [31:0] reqData;
  logic        reqAck = 1'b0;
  logic        ackErr = 1'b0;
  logic [31:0] ackData = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memcmd_front u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .reqAck(reqAck), .ackErr(ackErr), .ackData(ackData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a; #1;
    d = busRdata;
  endtask

  task automatic ack(input logic e, input logic [31:0] d);
    reqAck = 1'b1; ackErr = e; ackData = d;
    @(posedge clk); #1;
    reqAck = 1'b0; ackErr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] expRx;
    logic [31:0] pAddr;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(A_STAT, r); chk("R1 status", r, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 reqValid", {31'b0, reqValid}, 0);
    rd(A_RXD, r); chk("R1 rxdata", r, 0);

    // R2 readback and read-only receive data
    wr(A_ADDR, 32'hCAFE_0001); rd(A_ADDR, r); chk("R2 addr", r, 32'hCAFE_0001);
    wr(A_TXD, 32'h0F0F_1234);  rd(A_TXD, r);  chk("R2 txd", r, 32'h0F0F_1234);
    wr(A_RXD, 32'h1111_1111);  rd(A_RXD, r);  chk("R2 rxd ro", r, 0);

    // vector table: R3 R4 R5 R6 R10
    expRx = 32'h0;
    for (int i = 0; i < NV; i++) begin
      wr(A_ADDR, VECS[i].addr);
      wr(A_TXD, VECS[i].tx);
      wr(A_CMD, {KEY, 12'h0, VECS[i].op});
      chk("R3 valid", {31'b0, reqValid}, 1);
      chk("R3 op", {28'b0, reqOp}, {28'b0, VECS[i].op});
      chk("R3 addr", reqAddr, VECS[i].addr);
      chk("R3 data", reqData, VECS[i].tx);
      ack(VECS[i].aErr, VECS[i].aData);
      chk("R4 release", {31'b0, reqValid}, 0);
      rd(A_STAT, r);
      chk("R5 status", r, VECS[i].aErr ? 32'h2 : 32'h1);
      if (VECS[i].op == 4'h8 && !VECS[i].aErr) expRx = VECS[i].aData;
      rd(A_RXD, r); chk("R6 rxdata", r, expRx);
      wr(A_STAT, 32'h3);
      rd(A_STAT, r); chk("R10 clear", r, 0);
    end

    // R7 wrong key
    wr(A_CMD, {16'h5AA5, 12'h0, 4'h8});
    chk("R7 no request", {31'b0, reqValid}, 0);
    rd(A_STAT, r); chk("R7 err", r, 2);
    wr(A_STAT, 32'h3);

    // R8 host-bus and low opcodes
    wr(A_CMD, {KEY, 12'h0, 4'h1});
    chk("R8 op1 no request", {31'b0, reqValid}, 0);
    rd(A_STAT, r); chk("R8 op1 err", r, 2);
    wr(A_STAT, 32'h3);
    wr(A_CMD, {KEY, 12'h0, 4'h0});
    chk("R8 op0 no request", {31'b0, reqValid}, 0);
    rd(A_STAT, r); chk("R8 op0 err", r, 2);
    wr(A_STAT, 32'h3);
    wr(A_CMD, {KEY, 12'h0, 4'h7});
    chk("R8 op7 no request", {31'b0, reqValid}, 0);
    wr(A_STAT, 32'h3);

    // R4 hold + R9 busy write
    pAddr = 32'h0000_0077;
    wr(A_ADDR, pAddr);
    wr(A_CMD, {KEY, 12'h0, 4'hB});
    repeat (3) @(posedge clk); #1;
    chk("R4 hold valid", {31'b0, reqValid}, 1);
    chk("R4 hold addr", reqAddr, pAddr);
    wr(A_ADDR, 32'h0000_0099);
    wr(A_CMD, {KEY, 12'h0, 4'h9});
    rd(A_STAT, r); chk("R9 err", r, 2);
    chk("R9 op kept", {28'b0, reqOp}, 32'hB);
    chk("R9 addr kept", reqAddr, pAddr);
    ack(1'b0, 32'h0);
    chk("R9 single request", {31'b0, reqValid}, 0);
    rd(A_STAT, r); chk("R9 status", r, 3);

    // R10 partial clear
    wr(A_STAT, 32'h1);
    rd(A_STAT, r); chk("R10 partial", r, 2);
    wr(A_STAT, 32'h2);

    // R10 set and clear in one cycle
    wr(A_CMD, {KEY, 12'h0, 4'hE});
    reqAck = 1'b1; ackErr = 1'b0;
    busWr = 1'b1; busAddr = A_STAT; busWdata = 32'h1;
    @(posedge clk); #1;
    reqAck = 1'b0; busWr = 1'b0;
    rd(A_STAT, r); chk("R10 set wins", r, 1);

    // R11 interrupt gating (status = done only)
    wr(A_IEN, 32'h0); chk("R11 ien0", {31'b0, irq}, 0);
    wr(A_IEN, 32'h2); chk("R11 ien err only", {31'b0, irq}, 0);
    wr(A_IEN, 32'h1); chk("R11 ien done", {31'b0, irq}, 1);
    wr(A_STAT, 32'h1); chk("R11 cleared", {31'b0, irq}, 0);
    wr(A_IEN, 32'h2);
    wr(A_CMD, {16'h0000, 12'h0, 4'h8});
    chk("R11 err irq", {31'b0, irq}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule